// File: doc/BRIEF.md
# Timer Channel Match and Output Unit

This unit compares a free-running 16-bit timebase against a stored target time. When the target is reached it changes the level of one channel output and records the event in a small flag register. Two timebases come in, and a select input chooses which one the comparator watches. Software loads a target by pulsing a write strobe. That write arms the unit. The first qualifying compare after the write fires once, and the unit then stays idle until the next write.

Two compare modes are provided. In the default "reached or passed" mode, the unit takes the selected timebase minus the target, modulo 2^16. It treats the target as reached when that difference is below half the range. A target that is already in the past therefore fires at once, at the cost of a 15-bit usable window. In the exact mode, the unit fires only when the timebase equals the target, so the whole 16-bit range is available.

A per-event action code chooses what the firing does to the output: hold, drive high, drive low, or toggle. The output driver has an enable. An emergency disable input removes this enable through purely combinational logic, with no clock involved. The registered output level stays readable as a status condition at all times.

Top module: `chan_match_unit`

## Requirements
- R1: After reset the output level is 0, all three flags are 0 and the unit is disarmed, so no compare fires even if the timebase equals the reset target value 0x0000.
- R2: A cycle with `match_wr` high loads `match_val` as the target and arms the unit. Compares with the new target start in the following cycle, and a write cycle itself never fires.
- R3: In reached-or-passed mode (`eq_only`=0), an armed unit fires when (selected timebase − target) mod 65536 is below 0x8000. This includes a target already in the past and a difference that wraps through 0xFFFF.
- R4: In reached-or-passed mode, no firing occurs while that difference is 0x8000 or above, so a difference of exactly 0x8000 does not fire.
- R5: In exact mode (`eq_only`=1), an armed unit fires only when the selected timebase equals the target exactly, across the full 16-bit range.
- R6: `tb_sel`=0 compares against `tb_a` and `tb_sel`=1 compares against `tb_b`.
- R7: Each arming fires at most once. After firing, the output and flags stay unchanged until a new write re-arms the unit.
- R8: On firing, `out_act` (sampled in the firing cycle) updates the output: 2'b00 hold, 2'b01 drive 1, 2'b10 drive 0, 2'b11 invert.
- R9: Flag bit 0 sets on every firing. Flag bit 1 sets when a firing changes the output level. Flag bit 2 sets when a write arrives while the unit is still armed. Each flag becomes visible one clock after its event.
- R10: A 1 in bit i of `flag_clr` clears flag i at the next clock edge. A set event in the same cycle wins over the clear.
- R11: `out_dis`=1 forces `pin_oe` to 0 combinationally, with no clock edge in between. Releasing `out_dis` restores `pin_oe`=1 the same way.
- R12: `pin_state` always shows the registered output level. While the output is disabled, matching and output updates continue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_a | input | 16 | First timebase |
| tb_b | input | 16 | Second timebase |
| tb_sel | input | 1 | Timebase select (0 = tb_a, 1 = tb_b) |
| match_val | input | 16 | Target time to load |
| match_wr | input | 1 | Write strobe; loads target and arms |
| eq_only | input | 1 | 1 = exact match, 0 = reached-or-passed |
| out_act | input | 2 | Output action on firing |
| flag_clr | input | 3 | Write-one-to-clear for flags |
| out_dis | input | 1 | Asynchronous output disable |
| pin_out | output | 1 | Registered output level |
| pin_oe | output | 1 | Output driver enable |
| pin_state | output | 1 | Readable current output level |
| flags | output | 3 | Event flags {rearm, level change, match} |

## Verification
A write becomes an armed target at the next edge. A compare that hits then changes the output level and the flags at the edge after that, so a write driven on one falling edge shows its result two falling edges later. Timebase, select and action changes made while the unit is armed take effect at the next rising edge. The bench drives every input just after a falling edge and reads the outputs on the following falling edge. The output-enable path is the only exception: it is read a fraction of a cycle after `out_dis` moves and before any rising edge, which shows that no register sits in that path.

// File: rtl/cmu_pkg.sv
package cmu_pkg;

   typedef enum logic [1:0] {
      ACT_HOLD   = 2'b00,
      ACT_HIGH   = 2'b01,
      ACT_LOW    = 2'b10,
      ACT_TOGGLE = 2'b11
   } act_e;

   localparam int NUM_FLAGS = 3;
   localparam int FLG_MATCH = 0;
   localparam int FLG_LEVEL = 1;
   localparam int FLG_REARM = 2;

endpackage

// File: rtl/cmu_compare.sv
module cmu_compare #(
   parameter int TB_W       = 16,
   parameter bit SUPPORT_EQ = 1'b1
) (
   input  logic [TB_W-1:0] tb_a,
   input  logic [TB_W-1:0] tb_b,
   input  logic            tb_sel,
   input  logic [TB_W-1:0] cmp_val,
   input  logic            eq_only,
   output logic            hit
);

   logic [TB_W-1:0] sel_tb;
   logic [TB_W-1:0] diff;
   logic            ge_hit;

   assign sel_tb = tb_sel ? tb_b : tb_a;
   // Modular distance: top bit clear means "at or after target"
   assign diff   = sel_tb - cmp_val;
   assign ge_hit = ~diff[TB_W-1];

   generate
      if (SUPPORT_EQ) begin : g_eq_mode
         assign hit = eq_only ? (sel_tb == cmp_val) : ge_hit;
      end else begin : g_ge_only
         logic unused_mode;
         assign unused_mode = eq_only;
         assign hit = ge_hit;
      end
   endgenerate

endmodule

// File: rtl/cmu_arm.sv
module cmu_arm #(
   parameter int TB_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [TB_W-1:0] wr_val,
   input  logic            hit,
   output logic [TB_W-1:0] cmp_val,
   output logic            fire,
   output logic            rearm
);

   logic armed;

   assign fire  = armed & hit & ~wr;
   assign rearm = armed & wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_val <= '0;
         armed   <= 1'b0;
      end else if (wr) begin
         cmp_val <= wr_val;
         armed   <= 1'b1;
      end else if (fire) begin
         armed   <= 1'b0;
      end
   end

   // R2
   load_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (armed && cmp_val == $past(wr_val)));

   // R7
   single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !armed);

endmodule

// File: rtl/cmu_pin.sv
module cmu_pin
   import cmu_pkg::*;
#(
   parameter bit RESET_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  act_e act,
   output logic pin_q,
   output logic level_chg
);

   logic nxt;

   always_comb begin
      case (act)
         ACT_HIGH:   nxt = 1'b1;
         ACT_LOW:    nxt = 1'b0;
         ACT_TOGGLE: nxt = ~pin_q;
         default:    nxt = pin_q;
      endcase
   end

   assign level_chg = fire & (nxt != pin_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pin_q <= RESET_LEVEL;
      else if (fire) pin_q <= nxt;
   end

   // R7
   pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(pin_q));

   // R8
   toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && act == ACT_TOGGLE) |=> (pin_q != $past(pin_q)));

   // R8
   drive_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && act == ACT_HIGH) |=> pin_q);

endmodule

// File: rtl/cmu_flags.sv
module cmu_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flags
);

   genvar i;
   generate
      for (i = 0; i < N; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr[i]) flags[i] <= 1'b0;
         end

         // R10
         set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]);

         // R10
         clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !flags[i]);
      end
   endgenerate

endmodule

// File: rtl/chan_match_unit.sv
module chan_match_unit
   import cmu_pkg::*;
#(
   parameter int TB_W        = 16,
   parameter bit SUPPORT_EQ  = 1'b1,
   parameter bit RESET_LEVEL = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [TB_W-1:0]      tb_a,
   input  logic [TB_W-1:0]      tb_b,
   input  logic                 tb_sel,
   input  logic [TB_W-1:0]      match_val,
   input  logic                 match_wr,
   input  logic                 eq_only,
   input  logic [1:0]           out_act,
   input  logic [NUM_FLAGS-1:0] flag_clr,
   input  logic                 out_dis,
   output logic                 pin_out,
   output logic                 pin_oe,
   output logic                 pin_state,
   output logic [NUM_FLAGS-1:0] flags
);

   generate
      if (TB_W < 2) begin : g_bad_width
         $error("chan_match_unit: TB_W must be at least 2");
      end
   endgenerate

   logic [TB_W-1:0]      cmp_val;
   logic                 hit;
   logic                 fire;
   logic                 rearm;
   logic                 pin_q;
   logic                 level_chg;
   logic [NUM_FLAGS-1:0] flag_set;

   cmu_compare #(.TB_W(TB_W), .SUPPORT_EQ(SUPPORT_EQ)) u_cmp (
      .tb_a    (tb_a),
      .tb_b    (tb_b),
      .tb_sel  (tb_sel),
      .cmp_val (cmp_val),
      .eq_only (eq_only),
      .hit     (hit)
   );

   cmu_arm #(.TB_W(TB_W)) u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (match_wr),
      .wr_val  (match_val),
      .hit     (hit),
      .cmp_val (cmp_val),
      .fire    (fire),
      .rearm   (rearm)
   );

   cmu_pin #(.RESET_LEVEL(RESET_LEVEL)) u_pin (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (fire),
      .act       (act_e'(out_act)),
      .pin_q     (pin_q),
      .level_chg (level_chg)
   );

   always_comb begin
      flag_set            = '0;
      flag_set[FLG_MATCH] = fire;
      flag_set[FLG_LEVEL] = level_chg;
      flag_set[FLG_REARM] = rearm;
   end

   cmu_flags #(.N(NUM_FLAGS)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set),
      .clr   (flag_clr),
      .flags (flags)
   );

   // Disable path is a single gate, no register
   assign pin_oe    = ~out_dis;
   assign pin_out   = pin_q;
   assign pin_state = pin_q;

   // R9
   match_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> flags[FLG_MATCH]);

   // R5
   exact_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SUPPORT_EQ && fire && eq_only) |->
         ((tb_sel ? tb_b : tb_a) == cmp_val));

   // R2
   no_fire_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match_wr && !flag_clr[FLG_MATCH] && !flags[FLG_MATCH]) |=> !flags[FLG_MATCH]);

endmodule

// File: tb/chan_match_unit_tb.sv
module chan_match_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] tb_a = '0;
   logic [15:0] tb_b = '0;
   logic        tb_sel = 1'b0;
   logic [15:0] match_val = '0;
   logic        match_wr = 1'b0;
   logic        eq_only = 1'b0;
   logic [1:0]  out_act = 2'b00;
   logic [2:0]  flag_clr = '0;
   logic        out_dis = 1'b0;
   logic        pin_out, pin_oe, pin_state;
   logic [2:0]  flags;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   chan_match_unit u_dut (
      .clk(clk), .rst_n(rst_n), .tb_a(tb_a), .tb_b(tb_b), .tb_sel(tb_sel),
      .match_val(match_val), .match_wr(match_wr), .eq_only(eq_only),
      .out_act(out_act), .flag_clr(flag_clr), .out_dis(out_dis),
      .pin_out(pin_out), .pin_oe(pin_oe), .pin_state(pin_state), .flags(flags)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic write_match(input logic [15:0] v);
      @(negedge clk);
      match_val = v;
      match_wr  = 1'b1;
      @(negedge clk);
      match_wr  = 1'b0;
   endtask

   task automatic clear_all();
      @(negedge clk);
      flag_clr = 3'b111;
      @(negedge clk);
      flag_clr = 3'b000;
   endtask

   task automatic t_reset();
      chk("R1", "pin_out", pin_out, 0);
      chk("R1", "pin_oe", pin_oe, 1);
      chk("R1", "flags", flags, 0);
      tb_a = 16'h0000;
      repeat (3) @(negedge clk);
      chk("R1", "flags disarmed", flags, 0);
      chk("R1", "pin disarmed", pin_state, 0);
   endtask

   task automatic t_ge_past();
      tb_a = 16'h1000; out_act = 2'b01;
      write_match(16'h0F00);
      @(negedge clk);
      chk("R3", "past target pin", pin_out, 1);
      chk("R9", "flags after fire", flags, 3'b011);
      out_act = 2'b11;
      repeat (3) @(negedge clk);
      chk("R7", "pin held after fire", pin_out, 1);
      chk("R7", "flags held", flags, 3'b011);
      clear_all();
      chk("R10", "flags cleared", flags, 0);
   endtask

   task automatic t_ge_future();
      tb_a = 16'h1000; out_act = 2'b11;
      write_match(16'h1100);
      @(negedge clk);
      chk("R4", "future no fire", flags, 0);
      tb_a = 16'h1105;
      @(negedge clk);
      chk("R3", "passed toggles pin", pin_out, 0);
      chk("R3", "passed flags", flags, 3'b011);
      clear_all();
   endtask

   task automatic t_ge_edges();
      out_act = 2'b01;
      tb_a = 16'h9000;
      write_match(16'h1000);
      @(negedge clk);
      chk("R4", "diff 0x8000 no fire", flags, 0);
      tb_a = 16'h8FFF;
      @(negedge clk);
      chk("R3", "diff 0x7FFF fires", flags, 3'b011);
      chk("R8", "drive high", pin_out, 1);
      clear_all();
      out_act = 2'b10;
      tb_a = 16'h0005;
      write_match(16'hFFF0);
      @(negedge clk);
      chk("R3", "wrap fires", flags, 3'b011);
      chk("R8", "drive low", pin_out, 0);
      clear_all();
   endtask

   task automatic t_exact();
      eq_only = 1'b1; out_act = 2'b01;
      tb_a = 16'h1000;
      write_match(16'hA000);
      @(negedge clk);
      chk("R5", "exact ignores past", flags, 0);
      tb_a = 16'hA001;
      @(negedge clk);
      chk("R5", "exact ignores overshoot", flags, 0);
      tb_a = 16'hA000;
      @(negedge clk);
      chk("R5", "exact equal fires", flags, 3'b011);
      chk("R5", "exact pin", pin_out, 1);
      eq_only = 1'b0;
      clear_all();
   endtask

   task automatic t_select();
      tb_a = 16'h5000; tb_b = 16'h2000; tb_sel = 1'b1; out_act = 2'b10;
      write_match(16'h3000);
      @(negedge clk);
      chk("R6", "tb_b selected no fire", flags, 0);
      chk("R6", "pin kept", pin_out, 1);
      tb_sel = 1'b0;
      @(negedge clk);
      chk("R6", "tb_a selected fires", flags, 3'b011);
      chk("R6", "pin low", pin_out, 0);
      clear_all();
   endtask

   task automatic t_hold_rearm();
      out_act = 2'b00; tb_a = 16'h0000;
      write_match(16'h4000);
      @(negedge clk);
      chk("R2", "armed, not yet", flags, 0);
      write_match(16'h4000);
      chk("R9", "rearm flag", flags, 3'b100);
      tb_a = 16'h4000;
      @(negedge clk);
      chk("R8", "hold keeps pin", pin_out, 0);
      chk("R9", "no level flag on hold", flags, 3'b101);
      clear_all();
   endtask

   task automatic t_set_beats_clear();
      out_act = 2'b11; tb_a = 16'h0000;
      write_match(16'h6000);
      @(negedge clk);
      chk("R2", "pending", flags, 0);
      tb_a = 16'h6000; flag_clr = 3'b111;
      @(negedge clk);
      flag_clr = 3'b000;
      chk("R10", "set beats clear", flags, 3'b011);
      chk("R10", "pin toggled", pin_out, 1);
      clear_all();
   endtask

   task automatic t_disable();
      @(negedge clk);
      #1 out_dis = 1'b1;
      #0.5;
      chk("R11", "oe drops at once", pin_oe, 0);
      chk("R12", "state kept", pin_state, 1);
      out_act = 2'b10; tb_a = 16'h7000;
      write_match(16'h7000);
      @(negedge clk);
      chk("R12", "state follows fire", pin_state, 0);
      chk("R12", "flags while disabled", flags, 3'b011);
      chk("R11", "oe still off", pin_oe, 0);
      #1 out_dis = 1'b0;
      #0.5;
      chk("R11", "oe restored", pin_oe, 1);
      clear_all();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ge_past();
      t_ge_future();
      t_ge_edges();
      t_exact();
      t_select();
      t_hold_rearm();
      t_set_beats_clear();
      t_disable();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule